// File: doc/BRIEF.md
# Automatic serial flow controller

This block applies hardware and software flow control to one serial channel. On the receive side it watches the fill level of the receive FIFO. When the level climbs to a programmed halt threshold it enters a throttled state. It leaves that state only once the level has drained to or below a lower resume threshold. While throttled, and with automatic request-to-send enabled, it drives `rts` inactive. When software flow generation is enabled, it also asks the serialiser to send a stop character on entry to the throttled state, and a go character on exit.

On the transmit side it controls `tx_en`, which permits the serialiser to begin a new character. Two conditions hold `tx_en` low. The first is an inactive `cts` input while automatic clear-to-send is enabled. The second is a stop character received from the remote end while software flow honouring is enabled. A halt of either kind takes effect at a character boundary: while `tx_busy` shows a character in progress, `tx_en` stays high. A received go character ends a stop-character halt. An optional mode also lets any received character end it. Control characters that this block acts on are flagged so that they are not written into the receive FIFO. Special-character requests are independent of `tx_en`.

Top module: `serflow_ctl`

## Requirements
- R1: After reset `rts` is 1, `tx_en` is 1 and `spc_req` is 0.
- R2: With `cfg_rts_auto`=1, `rts` goes to 0 one clock after `rx_level` is at or above `halt_lvl` (resume_lvl < halt_lvl is assumed).
- R3: Once throttled, `rts` stays 0 while `rx_level` is above `resume_lvl`, and returns to 1 one clock after `rx_level` is at or below `resume_lvl`.
- R4: With `cfg_rts_auto`=0, `rts` stays 1 at any level.
- R5: With `cfg_sw_rx`=1, entering the throttled state raises `spc_req` one clock later with `spc_char`=`xoff_char`. `spc_req` holds until a clock with `spc_ack`=1 and is not raised again while the state persists.
- R6: With `cfg_sw_rx`=1, leaving the throttled state raises `spc_req` with `spc_char`=`xon_char`, held until `spc_ack`.
- R7: With `cfg_cts_auto`=1 and `cts`=0, `tx_en` is 0 unless `tx_busy`=1, in which case it stays 1. With `cfg_cts_auto`=0, `cts` has no effect.
- R8: With `cfg_sw_tx`=1, a received `xoff_char` (`rx_valid`=1) makes `tx_en` 0 from the next clock while `tx_busy`=0. Without any-resume mode, only a received `xon_char` restores it.
- R9: With `cfg_any_resume`=1, any received character ends a stop-character halt, and a character other than the go and stop values is still kept.
- R10: `rx_keep` equals `rx_valid`, except that it is 0 for a received `xon_char` or `xoff_char` while `cfg_sw_tx`=1. With `cfg_sw_tx`=0, those characters are kept and do not halt the transmitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rts_auto | input | 1 | Enable automatic RTS from thresholds |
| cfg_cts_auto | input | 1 | Enable transmit gating on CTS |
| cfg_sw_rx | input | 1 | Enable stop/go character generation |
| cfg_sw_tx | input | 1 | Enable honouring of received stop/go characters |
| cfg_any_resume | input | 1 | Any received character ends a stop halt |
| halt_lvl | input | LVL_W | Level at which throttling starts |
| resume_lvl | input | LVL_W | Level at or below which throttling ends |
| xon_char | input | CHAR_W | Go character value |
| xoff_char | input | CHAR_W | Stop character value |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| cts | input | 1 | Clear to send from remote, 1 = active |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CHAR_W | Received character |
| tx_busy | input | 1 | Serialiser has a character in progress |
| spc_ack | input | 1 | Serialiser accepted the special character |
| rts | output | 1 | Request to send, 1 = active |
| tx_en | output | 1 | Serialiser may start a new character |
| spc_req | output | 1 | Special-character send request |
| spc_char | output | CHAR_W | Special character to send |
| rx_keep | output | 1 | Write the received character into the FIFO |

## Verification
The bench steps the level through the band between the two thresholds. A design without hysteresis would raise `rts` as soon as the level dipped below the halt value. It holds the level above the halt value across several clocks with no acknowledge. A design that retriggers would then issue a second stop request after the acknowledge. It drops `cts` both with and without a character in flight, which exposes a design that cuts a character short. It also checks that an ordinary character leaves a stop halt in place until any-resume mode is on. A design that swallowed control characters with software flow disabled, or kept them with it enabled, is caught through `rx_keep`.

// File: rtl/serflow_ctl.sv
module serflow_ctl #(
  parameter int LVL_W  = 7,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rts_auto,
  input  logic              cfg_cts_auto,
  input  logic              cfg_sw_rx,
  input  logic              cfg_sw_tx,
  input  logic              cfg_any_resume,
  input  logic [LVL_W-1:0]  halt_lvl,
  input  logic [LVL_W-1:0]  resume_lvl,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              cts,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              tx_busy,
  input  logic              spc_ack,
  output logic              rts,
  output logic              tx_en,
  output logic              spc_req,
  output logic [CHAR_W-1:0] spc_char,
  output logic              rx_keep
);

  logic held, held_nxt, xoff_seen;

  wire is_xon  = rx_data == xon_char;
  wire is_xoff = rx_data == xoff_char;

  assign held_nxt = held ? (rx_level > resume_lvl) : (rx_level >= halt_lvl);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= 1'b0;
    else        held <= held_nxt;

  assign rts = !(cfg_rts_auto && held);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      spc_req  <= 1'b0;
      spc_char <= '0;
    end else if (cfg_sw_rx && held_nxt != held) begin
      spc_req  <= 1'b1;
      spc_char <= held_nxt ? xoff_char : xon_char;
    end else if (spc_ack) begin
      spc_req  <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                xoff_seen <= 1'b0;
    else if (!cfg_sw_tx)       xoff_seen <= 1'b0;
    else if (rx_valid) begin
      if (is_xoff)                      xoff_seen <= 1'b1;
      else if (is_xon || cfg_any_resume) xoff_seen <= 1'b0;
    end

  wire stop = (cfg_cts_auto && !cts) || xoff_seen;
  assign tx_en   = !stop || tx_busy;
  assign rx_keep = rx_valid && !(cfg_sw_tx && (is_xon || is_xoff));

endmodule

module serflow_ctl_chk #(
  parameter int LVL_W  = 7,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_rts_auto,
  input logic              cfg_sw_tx,
  input logic [LVL_W-1:0]  halt_lvl,
  input logic [LVL_W-1:0]  resume_lvl,
  input logic [CHAR_W-1:0] xoff_char,
  input logic [LVL_W-1:0]  rx_level,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_data,
  input logic              tx_busy,
  input logic              spc_ack,
  input logic              rts,
  input logic              tx_en,
  input logic              spc_req,
  input logic              held
);
  AST_HALT_DROPS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rts_auto && $past(rst_n) && $past(rx_level >= halt_lvl) && $past(resume_lvl < halt_lvl) |-> !rts); // R2
  AST_RESUME_RAISES_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rx_level <= resume_lvl) && $past(resume_lvl < halt_lvl) |-> rts); // R3
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    held && rx_level > resume_lvl |=> held); // R3
  AST_REQ_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    spc_req && !spc_ack |=> spc_req); // R5
  AST_XOFF_STOPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sw_tx && rx_valid && rx_data == xoff_char |=> (!tx_en || tx_busy)); // R8
endmodule

bind serflow_ctl serflow_ctl_chk #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/serflow_ctl_tb.sv
module serflow_ctl_tb;
  localparam int LW = 7;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_rts_auto = 0, cfg_cts_auto = 0, cfg_sw_rx = 0, cfg_sw_tx = 0, cfg_any_resume = 0;
  logic [LW-1:0] halt_lvl = 7'd48, resume_lvl = 7'd16, rx_level = 0;
  logic [CW-1:0] xon_char = 8'h11, xoff_char = 8'h13, rx_data = 0;
  logic cts = 1, rx_valid = 0, tx_busy = 0, spc_ack = 0;
  logic rts, tx_en, spc_req, rx_keep;
  logic [CW-1:0] spc_char;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serflow_ctl #(.LVL_W(LW), .CHAR_W(CW)) u_dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_char(input logic [CW-1:0] d, input logic exp_keep, input string tag);
    rx_valid = 1; rx_data = d;
    #1 chk(rx_keep, exp_keep, tag);
    step();
    rx_valid = 0;
    #1;
  endtask

  task automatic t_reset;
    chk(rts, 1, "R1 rts"); chk(tx_en, 1, "R1 tx_en"); chk(spc_req, 0, "R1 spc_req");
  endtask

  task automatic t_rts;
    cfg_rts_auto = 1;
    rx_level = 47; step(); chk(rts, 1, "R2 below halt");
    rx_level = 48; step(); chk(rts, 0, "R2 at halt");
    rx_level = 30; step(); chk(rts, 0, "R3 in band");
    rx_level = 17; step(); chk(rts, 0, "R3 above resume");
    rx_level = 16; step(); chk(rts, 1, "R3 at resume");
    cfg_rts_auto = 0;
    rx_level = 60; step(); chk(rts, 1, "R4 auto off");
    rx_level = 0; step(2);
    cfg_rts_auto = 1;
  endtask

  task automatic t_sw_rx;
    cfg_sw_rx = 1; rx_level = 0; step();
    rx_level = 50; step();
    chk(spc_req, 1, "R5 req"); chk(spc_char, 8'h13, "R5 xoff char");
    step(3); chk(spc_req, 1, "R5 held w/o ack");
    spc_ack = 1; step(); spc_ack = 0;
    chk(spc_req, 0, "R5 cleared by ack");
    step(3); chk(spc_req, 0, "R5 no repeat");
    rx_level = 10; step();
    chk(spc_req, 1, "R6 req"); chk(spc_char, 8'h11, "R6 xon char");
    spc_ack = 1; step(); spc_ack = 0;
    chk(spc_req, 0, "R6 cleared");
    cfg_sw_rx = 0; rx_level = 0; step();
  endtask

  task automatic t_cts;
    cfg_cts_auto = 1; cts = 0; tx_busy = 0;
    #1 chk(tx_en, 0, "R7 cts stop");
    tx_busy = 1; #1 chk(tx_en, 1, "R7 finish char");
    tx_busy = 0; cts = 1; #1 chk(tx_en, 1, "R7 cts back");
    cfg_cts_auto = 0; cts = 0; #1 chk(tx_en, 1, "R7 cts ignored");
    cts = 1; step();
  endtask

  task automatic t_sw_tx;
    cfg_sw_tx = 1; cfg_any_resume = 0;
    rx_char(8'h13, 0, "R10 xoff dropped");
    chk(tx_en, 0, "R8 xoff halts");
    rx_char(8'h41, 1, "R10 plain kept");
    chk(tx_en, 0, "R8 plain no resume");
    rx_char(8'h11, 0, "R10 xon dropped");
    chk(tx_en, 1, "R8 xon resumes");
    cfg_any_resume = 1;
    rx_char(8'h13, 0, "R9 xoff");
    chk(tx_en, 0, "R9 halted");
    rx_char(8'h41, 1, "R9 resume char kept");
    chk(tx_en, 1, "R9 any resumes");
    cfg_any_resume = 0; cfg_sw_tx = 0;
    rx_char(8'h13, 1, "R10 xoff kept when off");
    chk(tx_en, 1, "R10 no halt when off");
  endtask

  initial begin
    step(2); rst_n = 1; step();
    t_reset();
    t_rts();
    t_sw_rx();
    t_cts();
    t_sw_tx();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule